// File: doc/BRIEF.md
# Transmit Byte Queue with Threshold Flags

This block is a 64-entry byte queue that sits between a host register port and a bit serializer on the transmit side of a radio. The host pushes bytes one per cycle through a single write port, so a burst of writes to one data address lands as consecutive queue entries. The serializer pops them from the other end, seeing the oldest byte on the output whenever the queue holds data. An occupancy count is always visible.

Two programmable thresholds produce an almost-full and an almost-empty indication. Pushing into a full queue or popping from an empty one sets one shared sticky error flag that only a queue clear removes. Enable inputs gate the error and almost-full conditions onto an interrupt line. With automatic transmission enabled, the almost-full condition raises a transmit request.

Both data ports use valid/ready naming. Neither side can be stalled: the write port carries register-write strobes, so a beat with `wr_valid` high is taken in that cycle. If `wr_ready` is low at that moment the byte is dropped and counted as an overflow. The pop side asserts `rd_ready` for one cycle per byte. A pop while `rd_valid` is low is an underflow and shows 0x00 on `rd_data`.

Top module: `txq_fifo`

## Requirements
- R1: After reset the count is 0, `rd_valid` is 0, `wr_ready` is 1, the error flag, almost-full, interrupt and transmit request are 0, and almost-empty is 1.
- R2: Bytes leave in the order they were accepted. While `rd_valid` is 1, `rd_data` shows the oldest stored byte, and a pop with `rd_ready` removes it at the clock edge.
- R3: The queue holds 64 bytes. At 64 stored bytes `wr_ready` is 0 and the count reads 64.
- R4: A push while `wr_ready` is 0 is discarded: stored bytes and the count are unchanged, and the error flag sets.
- R5: A pop while `rd_valid` is 0 shows 0x00 on `rd_data` in that cycle, leaves the count at 0 and sets the error flag.
- R6: The error flag stays set until `clr`. A cycle with `clr` high empties the queue and clears the error flag. A push in that same cycle is dropped.
- R7: `afull` is 1 exactly when the count is strictly greater than the almost-full threshold. Its reset value is 48.
- R8: `aempty` is 1 exactly when the count is less than or equal to the almost-empty threshold. Its reset value is 4.
- R9: A cycle with `thr_load` high loads both thresholds from `thr_afull_in` and `thr_aempty_in` (6 bits each).
- R10: `irq` equals (error flag AND `err_ie`) OR (`afull` AND `afull_ie`).
- R11: `tx_req` equals `afull` AND `autotx_en`.
- R12: A push and a pop in the same cycle leave the count unchanged when the queue is neither empty nor full. When the queue is full, the pop is taken, the push is rejected as an overflow, and the count drops by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Queue clear; empties the queue and clears the error flag |
| wr_valid | input | 1 | Push strobe from the host data port |
| wr_data | input | 8 | Byte to push |
| wr_ready | output | 1 | Space available; a push while low is an overflow |
| rd_ready | input | 1 | Pop strobe from the serializer |
| rd_valid | output | 1 | Queue holds at least one byte |
| rd_data | output | 8 | Oldest byte, or 0x00 when empty |
| thr_load | input | 1 | Load both threshold registers |
| thr_afull_in | input | 6 | New almost-full threshold |
| thr_aempty_in | input | 6 | New almost-empty threshold |
| err_ie | input | 1 | Error interrupt enable |
| afull_ie | input | 1 | Almost-full interrupt enable |
| autotx_en | input | 1 | Automatic transmit enable |
| count | output | 7 | Stored byte count, 0 to 64 |
| afull | output | 1 | Almost-full indication |
| aempty | output | 1 | Almost-empty indication |
| err | output | 1 | Sticky overflow/underflow flag |
| irq | output | 1 | Gated interrupt |
| tx_req | output | 1 | Automatic transmit request |

## Verification
The assertions assume that every input has a known 0 or 1 value at each rising edge after reset. They also assume that the strobes are single-cycle requests that the block may refuse, not held transfers. The overflow property only covers a refused push with no pop and no clear in the same cycle, because those change the count on their own. The stimulus drives all inputs on the falling edge and drops the strobes shortly after the rising edge. Each push or pop therefore lasts exactly one clock, and every corner case, including the clear, push and pop collisions, is a deliberate single-cycle event.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef struct packed {
    logic afull;
    logic aempty;
    logic err;
  } txq_stat_t;

  function automatic int unsigned txq_addr_w(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = txq_pkg::txq_addr_w(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = txq_pkg::txq_addr_w(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_valid,
  input  logic          rd_ready,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          err
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CAP);
  assign empty = (count == '0);
  assign wr_ok = wr_valid && !full && !clr;
  assign rd_ok = rd_ready && !empty && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr <= '0;
      raddr <= '0;
      count <= '0;
      err   <= 1'b0;
    end else if (clr) begin
      waddr <= '0;
      raddr <= '0;
      count <= '0;
      err   <= 1'b0;
    end else begin
      if (wr_ok) waddr <= bump(waddr);
      if (rd_ok) raddr <= bump(raddr);
      unique case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if ((wr_valid && full) || (rd_ready && empty)) err <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !err); // R6
  AST_OVF_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !rd_ready && !clr) |=> $stable(count) && err); // R4
  AST_UNF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && empty && !clr) |=> err); // R5
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok) |=> $stable(count)); // R12
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned AF_THR_RST = 48,
  parameter int unsigned AE_THR_RST = 4,
  localparam int unsigned TW        = txq_pkg::txq_addr_w(DEPTH),
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_load,
  input  logic [TW-1:0] thr_afull_in,
  input  logic [TW-1:0] thr_aempty_in,
  input  logic [CW-1:0] count,
  input  logic          err,
  input  logic          err_ie,
  input  logic          afull_ie,
  input  logic          autotx_en,
  output txq_pkg::txq_stat_t stat,
  output logic          irq,
  output logic          tx_req
);
  logic [TW-1:0] af_thr, ae_thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      af_thr <= TW'(AF_THR_RST);
      ae_thr <= TW'(AE_THR_RST);
    end else if (thr_load) begin
      af_thr <= thr_afull_in;
      ae_thr <= thr_aempty_in;
    end
  end

  always_comb begin
    stat.afull  = (count > CW'(af_thr));
    stat.aempty = (count <= CW'(ae_thr));
    stat.err    = err;
  end

  assign irq    = (stat.err && err_ie) || (stat.afull && afull_ie);
  assign tx_req = stat.afull && autotx_en;

  AST_TXREQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (count != '0) && autotx_en); // R11
  AST_EMPTY_IS_AEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> stat.aempty && !stat.afull); // R8
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned DW         = 8,
  parameter int unsigned AF_THR_RST = 48,
  parameter int unsigned AE_THR_RST = 4,
  localparam int unsigned AW        = txq_pkg::txq_addr_w(DEPTH),
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          thr_load,
  input  logic [AW-1:0] thr_afull_in,
  input  logic [AW-1:0] thr_aempty_in,
  input  logic          err_ie,
  input  logic          afull_ie,
  input  logic          autotx_en,
  output logic [CW-1:0] count,
  output logic          afull,
  output logic          aempty,
  output logic          err,
  output logic          irq,
  output logic          tx_req
);
  logic          wr_ok, rd_ok, full, empty, err_q;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_q;
  txq_pkg::txq_stat_t stat;

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_valid(wr_valid), .rd_ready(rd_ready),
    .wr_ok(wr_ok), .rd_ok(rd_ok),
    .waddr(waddr), .raddr(raddr),
    .count(count), .full(full), .empty(empty), .err(err_q)
  );

  txq_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  txq_flags #(.DEPTH(DEPTH), .AF_THR_RST(AF_THR_RST), .AE_THR_RST(AE_THR_RST)) u_flags (
    .clk(clk), .rst_n(rst_n), .thr_load(thr_load),
    .thr_afull_in(thr_afull_in), .thr_aempty_in(thr_aempty_in),
    .count(count), .err(err_q), .err_ie(err_ie), .afull_ie(afull_ie),
    .autotx_en(autotx_en), .stat(stat), .irq(irq), .tx_req(tx_req)
  );

  assign wr_ready = !full;
  assign rd_valid = !empty;
  assign rd_data  = empty ? '0 : mem_q;
  assign afull    = stat.afull;
  assign aempty   = stat.aempty;
  assign err      = stat.err;

  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid) |-> (rd_data == '0)); // R5
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> (count == CW'(DEPTH)) && rd_valid); // R3
endmodule

// File: tb/txq_fifo_test.sv
module txq_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       rd_ready = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       thr_load = 1'b0;
  logic [5:0] thr_afull_in = '0;
  logic [5:0] thr_aempty_in = '0;
  logic       err_ie = 1'b0, afull_ie = 1'b0, autotx_en = 1'b0;
  logic [6:0] count;
  logic       afull, aempty, err, irq, tx_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txq_fifo uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .thr_load(thr_load), .thr_afull_in(thr_afull_in), .thr_aempty_in(thr_aempty_in),
    .err_ie(err_ie), .afull_ie(afull_ie), .autotx_en(autotx_en),
    .count(count), .afull(afull), .aempty(aempty), .err(err),
    .irq(irq), .tx_req(tx_req)
  );

  // op[24:23]: 0 idle, 1 push, 2 pop; data[22:15]; count after[14:8]; popped byte[7:0]
  localparam logic [24:0] VEC [13] = '{
    {2'd1, 8'hAA, 7'd1, 8'h00},
    {2'd1, 8'h5B, 7'd2, 8'h00},
    {2'd2, 8'h00, 7'd1, 8'hAA},
    {2'd1, 8'hC3, 7'd2, 8'h00},
    {2'd2, 8'h00, 7'd1, 8'h5B},
    {2'd2, 8'h00, 7'd0, 8'hC3},
    {2'd1, 8'h11, 7'd1, 8'h00},
    {2'd1, 8'h22, 7'd2, 8'h00},
    {2'd1, 8'h33, 7'd3, 8'h00},
    {2'd2, 8'h00, 7'd2, 8'h11},
    {2'd0, 8'h00, 7'd2, 8'h00},
    {2'd2, 8'h00, 7'd1, 8'h22},
    {2'd2, 8'h00, 7'd0, 8'h33}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wv, input logic [7:0] wd, input logic rr,
                     input logic cl, output logic [7:0] seen);
    @(negedge clk);
    wr_valid = wv; wr_data = wd; rd_ready = rr; clr = cl;
    #1 seen = rd_data;
    @(posedge clk);
    #1;
    wr_valid = 1'b0; rd_ready = 1'b0; clr = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 err", err, 0);
    chk("R1 aempty", aempty, 1);
    chk("R1 afull", afull, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_req", tx_req, 0);

    // R2 ordering via vector table
    for (int i = 0; i < 13; i++) begin
      logic [1:0] op;
      op = VEC[i][24:23];
      cyc(op == 2'd1, VEC[i][22:15], op == 2'd2, 1'b0, s);
      chk("R2 count", count, VEC[i][14:8]);
      if (op == 2'd2) chk("R2 order", s, VEC[i][7:0]);
    end
    chk("R2 no error", err, 0);

    // R8 default almost-empty threshold of 4
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'h40 + 8'(i), 1'b0, 1'b0, s);
    chk("R8 aempty at 4", aempty, 1);
    cyc(1'b1, 8'h44, 1'b0, 1'b0, s);
    chk("R8 aempty at 5", aempty, 0);
    chk("R7 afull default", afull, 0);

    // R9 threshold load
    @(negedge clk);
    thr_load = 1'b1; thr_afull_in = 6'd6; thr_aempty_in = 6'd2;
    @(posedge clk); #1 thr_load = 1'b0;
    cyc(1'b1, 8'h45, 1'b0, 1'b0, s);
    chk("R9 afull at 6", afull, 0);
    chk("R9 aempty new thr", aempty, 0);
    cyc(1'b1, 8'h46, 1'b0, 1'b0, s);
    chk("R7 afull at 7", afull, 1);
    chk("R11 tx_req off", tx_req, 0);
    chk("R10 irq gated", irq, 0);
    @(negedge clk); autotx_en = 1'b1; #1;
    chk("R11 tx_req on", tx_req, 1);
    afull_ie = 1'b1; #1;
    chk("R10 irq afull", irq, 1);
    autotx_en = 1'b0; afull_ie = 1'b0;

    // R3 capacity, R4 overflow
    for (int i = 7; i < 64; i++) cyc(1'b1, 8'h40 + 8'(i), 1'b0, 1'b0, s);
    chk("R3 count full", count, 64);
    chk("R3 wr_ready", wr_ready, 0);
    cyc(1'b1, 8'hEE, 1'b0, 1'b0, s);
    chk("R4 count kept", count, 64);
    chk("R4 err", err, 1);
    for (int i = 0; i < 64; i++) begin
      cyc(1'b0, 8'h00, 1'b1, 1'b0, s);
      chk("R4 data intact", s, 8'h40 + 8'(i));
    end
    chk("R6 err sticky", err, 1);
    @(negedge clk); err_ie = 1'b1; #1;
    chk("R10 irq err", irq, 1);
    err_ie = 1'b0;

    // R6 clear
    cyc(1'b0, 8'h00, 1'b0, 1'b1, s);
    chk("R6 err cleared", err, 0);
    chk("R6 count", count, 0);

    // R5 underflow
    cyc(1'b0, 8'h00, 1'b1, 1'b0, s);
    chk("R5 data zero", s, 0);
    chk("R5 count", count, 0);
    chk("R5 err", err, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, s);

    // R12 simultaneous push and pop
    cyc(1'b1, 8'h77, 1'b0, 1'b0, s);
    cyc(1'b1, 8'h88, 1'b1, 1'b0, s);
    chk("R12 popped", s, 8'h77);
    chk("R12 count held", count, 1);
    chk("R12 no err", err, 0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, s);
    chk("R2 next byte", s, 8'h88);
    for (int i = 0; i < 64; i++) cyc(1'b1, 8'(i), 1'b0, 1'b0, s);
    cyc(1'b1, 8'h99, 1'b1, 1'b0, s);
    chk("R12 full pop", s, 8'h00);
    chk("R12 full count", count, 63);
    chk("R12 full err", err, 1);

    // R6 clear beats push
    cyc(1'b1, 8'h55, 1'b0, 1'b1, s);
    chk("R6 clr with push count", count, 0);
    chk("R6 clr with push err", err, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule